// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is a two-address index/data configuration port of the kind found on legacy I/O controllers. A host byte bus selects one of two addresses with a single select bit. Offset 0 is the index address and offset 1 is the data address. The port stays closed until the unlock key 0x55 is written to the index address. While it is open, a write to the index address latches a register number, and the data address then reads or writes that register. Writing 0xAA to the index address closes the port again.

A device-select register chooses which bank of per-device registers is visible. This block implements one bank, the embedded controller at device number 0x0C. That bank holds an enable flag and a 16-bit base address. Unusually, the base address keeps its low byte at the lower index. The chip ID byte reads as one of two values, chosen by a strap input. The base address and the enable flag are driven out continuously for a downstream address decoder. A base address of zero marks the device as unconfigured.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the port is closed (`cfg_open`=0), the device select, index and enable flag are 0, and `ec_base` equals the parameter BASE_RST.
- R2: Writing 0x55 to the index address (`bus_sel`=0) while closed opens the port. Writing 0xAA to the index address while open closes it. `cfg_open` shows the state from the cycle after the strobe.
- R3: While closed, reads at either address return 0xFF, writes to the data address change no register, and index writes other than 0x55 leave the latched index unchanged.
- R4: While open, an index-address write of any value other than 0xAA latches that value as the index, and a read at the index address returns the latched index.
- R5: Index 0x07 is the device-select register. It can be read and written through the data address.
- R6: Index 0x20 reads 0xC6 when `id_sel`=0 and 0xC7 when `id_sel`=1. Writes to it have no effect.
- R7: Index 0x30 of device 0x0C holds the enable flag in bit 0. It reads back as {7'b0, flag} and drives `ec_enable`.
- R8: Index 0x66 of device 0x0C holds base-address bits 7:0 and index 0x67 holds bits 15:8. Both read back and drive `ec_base`.
- R9: When the device select is not 0x0C, indices 0x30, 0x66 and 0x67 read 0x00 and writes to them change nothing.
- R10: A read of any index not listed above returns 0x00.
- R11: `ec_active` is 1 exactly when the enable flag is 1 and `ec_base` is non-zero.
- R12: A write takes effect on the clock edge where `bus_we` is high. The outputs do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | 0 selects the index address, 1 selects the data address |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the address selected by `bus_sel` (combinational) |
| id_sel | input | 1 | Strap that chooses between the two chip ID values |
| cfg_open | output | 1 | Port is unlocked |
| ec_base | output | 16 | Base address of the embedded-controller device |
| ec_enable | output | 1 | Enable flag of the embedded-controller device |
| ec_active | output | 1 | Device is enabled and its base address is non-zero |

## Verification
Directed sequences cover the following cases:
- Writes made while the port is closed, which must leave nothing changed.
- The unlock and lock keys sent in both states, which separates a key from an ordinary index value.
- Base-address writes made with the wrong device selected and with the right one, which exposes any missing bank gate.
- Distinct low and high base bytes, which exposes a swapped byte order.

After these, a seeded random stream mixes every implemented index, unimplemented indices, both keys and the `id_sel` strap. After each write the stream compares both read addresses and all outputs against a bench model.

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl #(
  parameter logic [7:0]  UNLOCK_KEY = 8'h55,
  parameter logic [7:0]  LOCK_KEY   = 8'hAA,
  parameter logic [7:0]  EC_DEV     = 8'h0C,
  parameter logic [7:0]  ID_LO      = 8'hC6,
  parameter logic [7:0]  ID_HI      = 8'hC7,
  parameter logic [15:0] BASE_RST   = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        id_sel,
  output logic        cfg_open,
  output logic [15:0] ec_base,
  output logic        ec_enable,
  output logic        ec_active
);
  localparam logic [7:0] IX_DEV  = 8'h07;
  localparam logic [7:0] IX_ID   = 8'h20;
  localparam logic [7:0] IX_EN   = 8'h30;
  localparam logic [7:0] IX_BLO  = 8'h66;
  localparam logic [7:0] IX_BHI  = 8'h67;

  logic        open_q, en_q;
  logic [7:0]  idx_q, dev_q, reg_rd;
  logic [15:0] base_q;

  wire idx_wr = bus_we & ~bus_sel;
  wire dat_wr = bus_we & bus_sel & open_q;
  wire ec_vis = (dev_q == EC_DEV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      idx_q  <= 8'h00;
      dev_q  <= 8'h00;
      en_q   <= 1'b0;
      base_q <= BASE_RST;
    end else begin
      if (idx_wr) begin
        if (!open_q) begin
          if (bus_wdata == UNLOCK_KEY) open_q <= 1'b1;
        end else if (bus_wdata == LOCK_KEY) begin
          open_q <= 1'b0;
        end else begin
          idx_q <= bus_wdata;
        end
      end
      if (dat_wr) begin
        case (idx_q)
          IX_DEV: dev_q <= bus_wdata;
          IX_EN:  if (ec_vis) en_q <= bus_wdata[0];
          IX_BLO: if (ec_vis) base_q[7:0] <= bus_wdata;
          IX_BHI: if (ec_vis) base_q[15:8] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx_q)
      IX_DEV:  reg_rd = dev_q;
      IX_ID:   reg_rd = id_sel ? ID_HI : ID_LO;
      IX_EN:   reg_rd = ec_vis ? {7'b0, en_q} : 8'h00;
      IX_BLO:  reg_rd = ec_vis ? base_q[7:0] : 8'h00;
      IX_BHI:  reg_rd = ec_vis ? base_q[15:8] : 8'h00;
      default: reg_rd = 8'h00;
    endcase
  end

  assign bus_rdata = !open_q ? 8'hFF : (bus_sel ? reg_rd : idx_q);
  assign cfg_open  = open_q;
  assign ec_base   = base_q;
  assign ec_enable = en_q;
  assign ec_active = en_q & (base_q != 16'h0000);

  a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && bus_we && !bus_sel && bus_wdata == UNLOCK_KEY) |=> cfg_open);
  a_r2_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && bus_we && !bus_sel && bus_wdata == LOCK_KEY) |=> !cfg_open);
  a_r3_closed_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> bus_rdata == 8'hFF);
  a_r3_closed_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && bus_we && bus_sel) |=> ($stable(ec_base) && $stable(ec_enable)));
  a_r9_bank_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel && dev_q != EC_DEV) |=> ($stable(ec_base) && $stable(ec_enable)));
  a_r8_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && bus_we && bus_sel && idx_q == IX_BLO && dev_q == EC_DEV)
      |=> ec_base[7:0] == $past(bus_wdata));
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(ec_base) && $stable(ec_enable) && $stable(cfg_open)));
endmodule

// File: tb/cfgport_ctrl_tb_top.sv
module cfgport_ctrl_tb_top;
  localparam logic [15:0] RST_BASE = 16'h0A40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, bus_sel = 1'b0, bus_we = 1'b0, id_sel = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        cfg_open, ec_enable, ec_active;
  logic [15:0] ec_base;

  cfgport_ctrl #(.BASE_RST(RST_BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .id_sel(id_sel),
    .cfg_open(cfg_open), .ec_base(ec_base), .ec_enable(ec_enable),
    .ec_active(ec_active));

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic        m_open = 1'b0, m_en = 1'b0;
  logic [7:0]  m_idx = 8'h00, m_dev = 8'h00;
  logic [15:0] m_base = RST_BASE;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic sel);
    if (!m_open) return 8'hFF;
    if (!sel) return m_idx;
    case (m_idx)
      8'h07: return m_dev;
      8'h20: return id_sel ? 8'hC7 : 8'hC6;
      8'h30: return (m_dev == 8'h0C) ? {7'b0, m_en} : 8'h00;
      8'h66: return (m_dev == 8'h0C) ? m_base[7:0] : 8'h00;
      8'h67: return (m_dev == 8'h0C) ? m_base[15:8] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input logic sel, input logic [7:0] d);
    if (!sel) begin
      if (!m_open) begin if (d == 8'h55) m_open = 1'b1; end
      else if (d == 8'hAA) m_open = 1'b0;
      else m_idx = d;
    end else if (m_open) begin
      case (m_idx)
        8'h07: m_dev = d;
        8'h30: if (m_dev == 8'h0C) m_en = d[0];
        8'h66: if (m_dev == 8'h0C) m_base[7:0] = d;
        8'h67: if (m_dev == 8'h0C) m_base[15:8] = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
    model_wr(sel, d);
  endtask

  task automatic rd(input logic sel, input string req);
    bus_sel = sel;
    #1;
    chk(req, {8'h00, bus_rdata}, {8'h00, exp_rd(sel)});
  endtask

  task automatic outs();
    chk("R8 ec_base", ec_base, m_base);
    chk("R7 ec_enable", {15'b0, ec_enable}, {15'b0, m_en});
    chk("R11 ec_active", {15'b0, ec_active}, {15'b0, m_en && m_base != 16'h0});
    chk("R2 cfg_open", {15'b0, cfg_open}, {15'b0, m_open});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    rd(1'b1, "R1 closed data read");
    outs();
    chk("R1 reset base", ec_base, RST_BASE);

    wr(1'b1, 8'hFF);
    wr(1'b0, 8'h30);
    rd(1'b0, "R3 closed index read");
    rd(1'b1, "R3 closed data read");
    outs();
    wr(1'b0, 8'h55);
    outs();
    rd(1'b0, "R3 index unchanged while closed");

    wr(1'b0, 8'h30);
    rd(1'b0, "R4 index readback");
    wr(1'b0, 8'h66); wr(1'b1, 8'h12);
    rd(1'b1, "R9 wrong bank reads zero");
    outs();

    wr(1'b0, 8'h07); wr(1'b1, 8'h0C);
    rd(1'b1, "R5 device select");
    wr(1'b0, 8'h20);
    rd(1'b1, "R6 id strap 0");
    id_sel = 1'b1;
    rd(1'b1, "R6 id strap 1");
    wr(1'b1, 8'h00);
    rd(1'b1, "R6 id write ignored");

    wr(1'b0, 8'h66); wr(1'b1, 8'h34);
    wr(1'b0, 8'h67); wr(1'b1, 8'h12);
    chk("R8 byte order", ec_base, 16'h1234);
    rd(1'b1, "R8 high byte readback");
    wr(1'b0, 8'h30); wr(1'b1, 8'hFF);
    rd(1'b1, "R7 enable readback");
    outs();
    wr(1'b0, 8'h45);
    rd(1'b1, "R10 unimplemented index");

    wr(1'b0, 8'h66);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = 8'h99;
    #1 chk("R12 no change before edge", ec_base, m_base);
    @(posedge clk);
    #1 bus_we = 1'b0;
    model_wr(1'b1, 8'h99);
    chk("R12 change after edge", ec_base, 16'h1299);

    wr(1'b0, 8'h66); wr(1'b1, 8'h00);
    wr(1'b0, 8'h67); wr(1'b1, 8'h00);
    chk("R11 zero base inactive", {15'b0, ec_active}, 16'h0);

    wr(1'b0, 8'hAA);
    outs();
    rd(1'b0, "R2 locked index read");
    wr(1'b1, 8'h77);
    outs();
    wr(1'b0, 8'h55); wr(1'b0, 8'h55);
    rd(1'b0, "R4 key value latched while open");

    void'($urandom(32'h5EED));
    for (int i = 0; i < 600; i++) begin
      logic s;
      logic [7:0] d;
      s = 1'($urandom % 2);
      if (!s) begin
        case ($urandom % 9)
          0: d = 8'h07; 1: d = 8'h20; 2: d = 8'h30; 3: d = 8'h66;
          4: d = 8'h67; 5: d = 8'h55; 6: d = 8'hAA;
          default: d = 8'($urandom);
        endcase
      end else begin
        d = ($urandom % 3 == 0) ? 8'h0C : 8'($urandom);
      end
      if ($urandom % 16 == 0) id_sel = ~id_sel;
      wr(s, d);
      rd(1'b0, "R4 random index read");
      rd(1'b1, "R10 random data read");
      outs();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule